// File: doc/BRIEF.md
# Three-Row Linear CCD Drive Clock Sequencer

This block turns a fast system clock into the logic-level drive waveforms for a three-row linear CCD sensor. Once per line it raises a transfer-gate pulse that all three rows share. It keeps the first shift clock parked in its transfer level for a guard interval on both sides of that pulse. It then clocks one full line out of the sensor's analog shift registers with a pair of complementary shift clocks. A reset-gate pulse runs once in every pixel period and never stops, not even during the transfer gate. A sample strobe and a two-bit pixel-class tag mark each pixel for the converter downstream.

Software writes the pixel period and the line period, both counted in system clocks, with a single load strobe. A load is validated on arrival. A pixel period must keep the pixel rate between 1 MHz and 4 MHz, and it must leave room for the reset pulse and its guard gaps inside the first half of the pixel. A line period must hold the guards, the transfer pulse, one alignment pixel and the whole readout. A bad load is refused with a one-cycle flag. A good load waits and takes effect at the next line boundary, so a line in progress is never disturbed.

With default parameters a line reads out 5369 pixels: 15 dummy, 49 optical black, 2 invalid, 5300 image and 3 invalid. The region sizes, the guard, the gate width and the reset timing are all parameters.

Top module: `ccd_clock_gen`

## Requirements
- R1: Each line gives exactly one `sample_stb` per pixel, in the last system cycle of that pixel period, so strobes are P cycles apart (P = active pixel period). The first strobe comes P-1 cycles after `line_start`, and `sample_stb` is never high while `xfer_gate` is high. `px_class` follows pixel order with the code 0 = dummy, 1 = optical black, 2 = invalid, 3 = image.
- R2: `line_start` is high for exactly one cycle, in the first cycle of the first pixel of the readout.
- R3: `xfer_gate` is high for exactly TG_CYC consecutive cycles once per line. Consecutive rising edges are spaced by the active line period.
- R4: `shift_a` is high whenever `xfer_gate` is high. It is also high for at least GUARD_CYC cycles before the gate rises, and it stays high for at least GUARD_CYC cycles after the gate falls.
- R5: `shift_b` is always the complement of `shift_a`. During readout `shift_a` is high for the first floor(P/2) cycles of each pixel.
- R6: `reset_gate` is high for exactly RS_CYC cycles once in every pixel period, also while `xfer_gate` is high. During readout its rising edges are P cycles apart.
- R7: Each `reset_gate` rising edge comes at least RS_GAP cycles after the last `shift_a` edge. Each `shift_a` edge comes at least RS_GAP cycles after the last `reset_gate` falling edge.
- R8: A load whose pixel period lies outside [P_MIN, P_MAX] is refused. Here P_MAX is the system clock in MHz, and P_MIN is the larger of ceil(MHz/4) and 2*(RS_CYC+2*RS_GAP). A refused load raises `cfg_rej` for the one cycle after the load and leaves the timing unchanged.
- R9: A load whose line period is below 2*GUARD_CYC + TG_CYC + (Npix+1)*P is refused in the same way. A load exactly at that minimum is accepted.
- R10: Accepted settings take effect at the next line boundary. The line in progress keeps its old pixel and line periods.
- R11: During reset `xfer_gate`, `reset_gate`, `sample_stb`, `line_start` and `cfg_rej` are low, `shift_a` is high and `shift_b` is low. After reset the pixel period is P_MIN and the line period is the minimum line for P_MIN.
- R12: The readout begins at the first pixel boundary after the post-gate guard, so that `line_start` comes between GUARD_CYC+1 and GUARD_CYC+P cycles after the first cycle in which `xfer_gate` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the two period values |
| cfg_pix_cyc | input | PW | Requested pixel period in system cycles |
| cfg_line_cyc | input | LW | Requested line period in system cycles |
| cfg_rej | output | 1 | One-cycle flag: the previous load was refused |
| xfer_gate | output | 1 | Transfer-gate pulse shared by all rows |
| shift_a | output | 1 | First shift-register clock (high = transfer level) |
| shift_b | output | 1 | Second shift-register clock, complement of shift_a |
| reset_gate | output | 1 | Per-pixel reset-gate pulse |
| sample_stb | output | 1 | Converter sample strobe, one per read pixel |
| px_class | output | 2 | Class of the pixel being strobed |
| line_start | output | 1 | One-cycle marker at the start of readout |

## Verification
On every cycle the assertions check the gate width, the shift clock parked high across the gate and its guard windows, the reset pulse width, the spacing between reset edges and shift-clock edges, the single-cycle line marker, and that no strobe falls inside the gate. Other behaviours can only show up in the bench's scenarios. These include the pixel-class order over a whole line, the strobe and line spacing under two different pixel periods, the refusal of out-of-range loads, the acceptance of a load exactly at the line minimum, and the deferral of a new setting to the next line boundary.

// File: rtl/ccdt_pkg.sv
package ccdt_pkg;

  typedef enum logic [1:0] {
    PXC_DUMMY = 2'd0,
    PXC_BLACK = 2'd1,
    PXC_VOID  = 2'd2,
    PXC_IMAGE = 2'd3
  } pxc_t;

  typedef enum logic [2:0] {
    SQ_LEAD, SQ_GATE, SQ_TAIL, SQ_ALIGN, SQ_READ, SQ_IDLE
  } seq_t;

  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction

  // shortest pixel period: 4 MHz ceiling, and reset pulse plus gaps within half a pixel
  function automatic int pix_cyc_min(int mhz, int rsw, int gap);
    int by_rate;
    int by_rs;
    by_rate = ceil_div(mhz, 4);
    by_rs   = 2 * (rsw + 2 * gap);
    return (by_rate > by_rs) ? by_rate : by_rs;
  endfunction

  // longest pixel period: 1 MHz floor
  function automatic int pix_cyc_max(int mhz);
    return mhz;
  endfunction

  // guards + gate + worst-case alignment pixel + readout
  function automatic int line_cyc_min(int guard, int gate, int npix, int pcyc);
    return 2 * guard + gate + (npix + 1) * pcyc;
  endfunction

  function automatic pxc_t class_of(int idx, int nd, int nob, int nlead, int nval);
    if (idx < nd)                       return PXC_DUMMY;
    if (idx < nd + nob)                 return PXC_BLACK;
    if (idx < nd + nob + nlead)         return PXC_VOID;
    if (idx < nd + nob + nlead + nval)  return PXC_IMAGE;
    return PXC_VOID;
  endfunction

endpackage

// File: rtl/ccdt_phase.sv
module ccdt_phase #(
  parameter int PW  = 8,
  parameter int RSW = 31,
  parameter int GAP = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pcyc,
  output logic [PW-1:0] ph,
  output logic          ph_wrap,
  output logic          rs_on,
  output logic          first_half
);
  localparam logic [PW-1:0] RS_LO = PW'(GAP);
  localparam logic [PW-1:0] RS_HI = PW'(GAP + RSW);

  assign ph_wrap    = ph >= (pcyc - PW'(1));
  assign rs_on      = (ph >= RS_LO) && (ph < RS_HI);
  assign first_half = ph < (pcyc >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph_wrap ? '0 : ph + PW'(1);
  end
endmodule

// File: rtl/ccdt_seq.sv
module ccdt_seq
  import ccdt_pkg::*;
#(
  parameter int LW    = 20,
  parameter int XW    = 13,
  parameter int NPIX  = 5369,
  parameter int GUARD = 125,
  parameter int GATE  = 1250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] line_cyc,
  input  logic          ph_wrap,
  output logic          gate_on,
  output logic          reading,
  output logic [XW-1:0] pix,
  output logic          line_wrap
);
  localparam logic [LW-1:0] END_LEAD = LW'(GUARD - 1);
  localparam logic [LW-1:0] END_GATE = LW'(GUARD + GATE - 1);
  localparam logic [LW-1:0] END_TAIL = LW'(2 * GUARD + GATE - 1);
  localparam logic [XW-1:0] LAST_PX  = XW'(NPIX - 1);

  seq_t          st;
  logic [LW-1:0] lcnt;

  assign line_wrap = lcnt >= (line_cyc - LW'(1));
  assign gate_on   = (st == SQ_GATE);
  assign reading   = (st == SQ_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SQ_LEAD;
      lcnt <= '0;
      pix  <= '0;
    end else begin
      lcnt <= line_wrap ? '0 : lcnt + LW'(1);
      if (line_wrap) st <= SQ_LEAD;
      else begin
        case (st)
          SQ_LEAD:  if (lcnt == END_LEAD) st <= SQ_GATE;
          SQ_GATE:  if (lcnt == END_GATE) st <= SQ_TAIL;
          SQ_TAIL:  if (lcnt == END_TAIL) st <= SQ_ALIGN;
          SQ_ALIGN: if (ph_wrap) begin
                      st  <= SQ_READ;
                      pix <= '0;
                    end
          SQ_READ:  if (ph_wrap) begin
                      if (pix == LAST_PX) st <= SQ_IDLE;
                      else                pix <= pix + XW'(1);
                    end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ccdt_cfg.sv
module ccdt_cfg #(
  parameter int PW    = 8,
  parameter int LW    = 20,
  parameter int P_MIN = 90,
  parameter int P_MAX = 125,
  parameter int OVH   = 1500,
  parameter int NPIX  = 5369
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_pix,
  input  logic [LW-1:0] cfg_line,
  input  logic          line_wrap,
  output logic [PW-1:0] act_pix,
  output logic [LW-1:0] act_line,
  output logic          cfg_rej
);
  localparam int XW       = LW + PW + 1;
  localparam int DEF_LINE = OVH + (NPIX + 1) * P_MIN;

  logic [PW-1:0] pend_pix;
  logic [LW-1:0] pend_line;
  logic [XW-1:0] need;
  logic          rate_ok, len_ok, accept;

  always_comb begin
    need    = XW'(OVH) + XW'(NPIX + 1) * XW'(cfg_pix);
    rate_ok = (cfg_pix >= PW'(P_MIN)) && (cfg_pix <= PW'(P_MAX));
    len_ok  = XW'(cfg_line) >= need;
    accept  = rate_ok && len_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_pix  <= PW'(P_MIN);
      pend_line <= LW'(DEF_LINE);
      act_pix   <= PW'(P_MIN);
      act_line  <= LW'(DEF_LINE);
      cfg_rej   <= 1'b0;
    end else begin
      cfg_rej <= cfg_we && !accept;
      if (cfg_we && accept) begin
        pend_pix  <= cfg_pix;
        pend_line <= cfg_line;
      end
      if (line_wrap) begin
        act_pix  <= pend_pix;
        act_line <= pend_line;
      end
    end
  end
endmodule

// File: rtl/ccd_clock_gen.sv
module ccd_clock_gen
  import ccdt_pkg::*;
#(
  parameter int SYS_MHZ    = 125,
  parameter int N_DUMMY    = 15,
  parameter int N_BLACK    = 49,
  parameter int N_LEAD_INV = 2,
  parameter int N_IMAGE    = 5300,
  parameter int N_TAIL_INV = 3,
  parameter int TG_CYC     = 1250,
  parameter int GUARD_CYC  = 125,
  parameter int RS_CYC     = 31,
  parameter int RS_GAP     = 7,
  parameter int PW         = 8,
  parameter int LW         = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_pix_cyc,
  input  logic [LW-1:0] cfg_line_cyc,
  output logic          cfg_rej,
  output logic          xfer_gate,
  output logic          shift_a,
  output logic          shift_b,
  output logic          reset_gate,
  output logic          sample_stb,
  output logic [1:0]    px_class,
  output logic          line_start
);
  localparam int NPIX  = N_DUMMY + N_BLACK + N_LEAD_INV + N_IMAGE + N_TAIL_INV;
  localparam int XW    = $clog2(NPIX + 1);
  localparam int P_MIN = pix_cyc_min(SYS_MHZ, RS_CYC, RS_GAP);
  localparam int P_MAX = pix_cyc_max(SYS_MHZ);
  localparam int OVH   = 2 * GUARD_CYC + TG_CYC;

  logic [PW-1:0] act_pix, ph;
  logic [LW-1:0] act_line;
  logic [XW-1:0] pix;
  logic          ph_wrap, rs_on, first_half;
  logic          gate_on, reading, line_wrap;

  ccdt_cfg #(.PW(PW), .LW(LW), .P_MIN(P_MIN), .P_MAX(P_MAX), .OVH(OVH), .NPIX(NPIX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pix(cfg_pix_cyc), .cfg_line(cfg_line_cyc),
    .line_wrap(line_wrap), .act_pix(act_pix), .act_line(act_line), .cfg_rej(cfg_rej)
  );

  ccdt_phase #(.PW(PW), .RSW(RS_CYC), .GAP(RS_GAP)) u_phase (
    .clk(clk), .rst_n(rst_n), .pcyc(act_pix), .ph(ph), .ph_wrap(ph_wrap),
    .rs_on(rs_on), .first_half(first_half)
  );

  ccdt_seq #(.LW(LW), .XW(XW), .NPIX(NPIX), .GUARD(GUARD_CYC), .GATE(TG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .line_cyc(act_line), .ph_wrap(ph_wrap),
    .gate_on(gate_on), .reading(reading), .pix(pix), .line_wrap(line_wrap)
  );

  // shift_a parks high outside readout, toggles at the pixel rate inside it
  assign xfer_gate  = gate_on;
  assign shift_a    = !reading || first_half;
  assign shift_b    = !shift_a;
  assign reset_gate = rs_on;
  assign sample_stb = reading && ph_wrap;
  assign line_start = reading && (pix == '0) && (ph == '0);
  assign px_class   = class_of(int'(pix), N_DUMMY, N_BLACK, N_LEAD_INV, N_IMAGE);
endmodule

// File: rtl/ccd_clock_gen_chk.sv
module ccd_clock_gen_chk #(
  parameter int TG_CYC    = 1250,
  parameter int GUARD_CYC = 125,
  parameter int RS_CYC    = 31,
  parameter int RS_GAP    = 7
) (
  input logic clk,
  input logic rst_n,
  input logic xfer_gate,
  input logic shift_a,
  input logic reset_gate,
  input logic sample_stb,
  input logic line_start,
  input logic cfg_we,
  input logic cfg_rej
);
  localparam int SAT = 1 << 20;

  int   hi_run, since_gate, gate_run, rs_run, since_edge;
  logic shift_a_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run     <= 0;
      since_gate <= 0;
      gate_run   <= 0;
      rs_run     <= 0;
      since_edge <= SAT;
      shift_a_q  <= 1'b1;
    end else begin
      shift_a_q  <= shift_a;
      hi_run     <= shift_a ? ((hi_run < SAT) ? hi_run + 1 : hi_run) : 0;
      since_gate <= xfer_gate ? 0 : ((since_gate < SAT) ? since_gate + 1 : since_gate);
      gate_run   <= xfer_gate ? gate_run + 1 : 0;
      rs_run     <= reset_gate ? rs_run + 1 : 0;
      since_edge <= (shift_a != shift_a_q) ? 1 : ((since_edge < SAT) ? since_edge + 1 : since_edge);
    end
  end

  assert_gate_parks_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gate |-> shift_a);
  assert_pre_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_gate) |-> hi_run >= GUARD_CYC);
  assert_post_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_a) |-> since_gate >= GUARD_CYC);
  assert_gate_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_gate) |-> gate_run == TG_CYC);
  assert_rs_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_gate) |-> rs_run == RS_CYC);
  assert_rs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_gate) |-> since_edge >= RS_GAP);
  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);
  assert_no_strobe_in_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !xfer_gate);
  assert_reject_follows_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rej |-> $past(cfg_we));
endmodule

bind ccd_clock_gen ccd_clock_gen_chk #(
  .TG_CYC(TG_CYC), .GUARD_CYC(GUARD_CYC), .RS_CYC(RS_CYC), .RS_GAP(RS_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_gate(xfer_gate), .shift_a(shift_a),
  .reset_gate(reset_gate), .sample_stb(sample_stb), .line_start(line_start),
  .cfg_we(cfg_we), .cfg_rej(cfg_rej)
);

// File: tb/ccd_clock_gen_test.sv
module ccd_clock_gen_test;
  localparam int MHZ  = 125;
  localparam int NV   = 8;
  localparam int NPIX = 15 + 49 + 2 + NV + 3;
  localparam int G    = 113;
  localparam int T    = 375;
  localparam int RSW  = 14;
  localparam int GAP  = 3;
  localparam int PDEF = 40;                          // max(ceil(125/4), 2*(14+6))
  localparam int LDEF = 2 * G + T + (NPIX + 1) * PDEF; // 3721

  typedef struct { int cls; int per; } exp_t;

  logic       clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_pix = '0;
  logic [19:0] cfg_line = '0;
  logic       cfg_rej, xfer_gate, shift_a, shift_b, reset_gate, sample_stb, line_start;
  logic [1:0] px_class;

  ccd_clock_gen #(.SYS_MHZ(MHZ), .N_IMAGE(NV), .TG_CYC(T), .GUARD_CYC(G),
                  .RS_CYC(RSW), .RS_GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pix_cyc(cfg_pix), .cfg_line_cyc(cfg_line),
    .cfg_rej(cfg_rej), .xfer_gate(xfer_gate), .shift_a(shift_a), .shift_b(shift_b),
    .reset_gate(reset_gate), .sample_stb(sample_stb), .px_class(px_class), .line_start(line_start)
  );

  always #4 clk = ~clk;

  int   total = 0, bad = 0, cyc = 0;
  exp_t q_px[$];
  int   q_len[$];
  bit   done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_class(int i);
    if (i < 15) return 0;
    if (i < 64) return 1;
    if (i < 66) return 2;
    if (i < 66 + NV) return 3;
    return 2;
  endfunction

  task automatic push_line(int per);
    for (int i = 0; i < NPIX; i++) begin
      exp_t e;
      e.cls = exp_class(i);
      e.per = per;
      q_px.push_back(e);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor / scoreboard
  int  tg_rise_t = 0, tg_fall_t = 0, tg_rises = 0, rs_in_tg = 0;
  int  rs_rise_t = -1000, rs_fall_t = -1000, edge_t = -1000, ls_t = 0, stb_t = 0;
  int  hi_run = 0, n_in_line = 0, cur_per = 0, ls_count = 0, strobes = 0;
  bit  tg_q = 0, a_q = 1, rs_q = 0, ls_q = 0, in_read = 0, wait_fall = 0, first_fall = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk(shift_b == !shift_a, "R5 complement", int'(shift_b), int'(!shift_a));
      if (xfer_gate && !shift_a) chk(0, "R4 shift high in gate", 0, 1);
      if (xfer_gate && !tg_q) begin
        chk(hi_run >= G, "R4 pre-gate guard", hi_run, G);
        if (tg_rises > 0 && q_len.size() > 0) begin
          int el;
          el = q_len.pop_front();
          chk(cyc - tg_rise_t == el, "R3 line period", cyc - tg_rise_t, el);
        end
        tg_rises++;
        tg_rise_t = cyc;
        rs_in_tg  = 0;
      end
      if (!xfer_gate && tg_q) begin
        chk(cyc - tg_rise_t == T, "R3 gate width", cyc - tg_rise_t, T);
        chk(rs_in_tg >= 2, "R6 reset during gate", rs_in_tg, 2);
        tg_fall_t = cyc;
        wait_fall = 1;
      end
      if (shift_a != a_q) begin
        chk(cyc - rs_fall_t >= GAP, "R7 shift edge after reset", cyc - rs_fall_t, GAP);
        if (!shift_a && wait_fall) begin
          chk(cyc - tg_fall_t >= G, "R4 post-gate guard", cyc - tg_fall_t, G);
          wait_fall = 0;
        end
        if (!shift_a && first_fall) begin
          chk(cyc - ls_t == cur_per / 2, "R5 half pixel high", cyc - ls_t, cur_per / 2);
          first_fall = 0;
        end
        edge_t = cyc;
      end
      if (reset_gate && !rs_q) begin
        chk(cyc - edge_t >= GAP, "R7 reset after shift edge", cyc - edge_t, GAP);
        if (in_read) chk(cyc - rs_rise_t == cur_per, "R6 reset period", cyc - rs_rise_t, cur_per);
        if (xfer_gate) rs_in_tg++;
        rs_rise_t = cyc;
      end
      if (!reset_gate && rs_q) begin
        chk(cyc - rs_rise_t == RSW, "R6 reset width", cyc - rs_rise_t, RSW);
        rs_fall_t = cyc;
      end
      if (line_start) begin
        if (ls_q) chk(0, "R2 single cycle", 1, 0);
        else begin
          cur_per = (q_px.size() > 0) ? q_px[0].per : 0;
          chk((cyc - tg_fall_t >= G + 1) && (cyc - tg_fall_t <= G + cur_per),
              "R12 readout alignment", cyc - tg_fall_t, G + 1);
          chk(shift_a == 1'b1, "R2 start in first half", int'(shift_a), 1);
          in_read = 1; first_fall = 1; n_in_line = 0; ls_t = cyc; ls_count++;
        end
      end
      if (sample_stb) begin
        if (!in_read || q_px.size() == 0) chk(0, "R1 unexpected strobe", n_in_line, NPIX);
        else begin
          exp_t e;
          e = q_px.pop_front();
          chk(int'(px_class) == e.cls, "R1 pixel class", int'(px_class), e.cls);
          if (n_in_line == 0) chk(cyc - ls_t == e.per - 1, "R1 first strobe", cyc - ls_t, e.per - 1);
          else chk(cyc - stb_t == e.per, "R1 strobe spacing", cyc - stb_t, e.per);
          n_in_line++;
          if (n_in_line == NPIX) in_read = 0;
        end
        stb_t = cyc;
        strobes++;
      end
      hi_run = shift_a ? hi_run + 1 : 0;
      tg_q = xfer_gate; a_q = shift_a; rs_q = reset_gate; ls_q = line_start;
    end
  end

  task automatic do_load(int p, int l, bit exp_rej, string req);
    cfg_pix = 8'(p); cfg_line = 20'(l); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rej == exp_rej, req, int'(cfg_rej), int'(exp_rej));
    @(negedge clk);
    chk(cfg_rej == 1'b0, req, int'(cfg_rej), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(xfer_gate == 0, "R11 gate low", int'(xfer_gate), 0);
    chk(shift_a == 1 && shift_b == 0, "R11 shift parked", int'(shift_a), 1);
    chk(reset_gate == 0, "R11 reset low", int'(reset_gate), 0);
    chk(sample_stb == 0 && line_start == 0, "R11 strobe low", int'(sample_stb), 0);
    chk(cfg_rej == 0, "R11 reject low", int'(cfg_rej), 0);
    // defaults: two lines at PDEF/LDEF (R11), third line already at new setting (R10)
    push_line(PDEF); push_line(PDEF);
    q_len.push_back(LDEF); q_len.push_back(LDEF);
    rst_n = 1'b1;
    wait (ls_count == 2);
    @(negedge clk);
    do_load(PDEF - 1, 4000, 1, "R8 period too short");
    do_load(MHZ + 1, 20000, 1, "R8 period too long");
    do_load(PDEF, LDEF - 1, 1, "R9 line too short");
    do_load(50, 2 * G + T + (NPIX + 1) * 50, 0, "R9 line at minimum");
    // R10: current line keeps LDEF, next lines use 50 / 4501
    push_line(50); push_line(50);
    q_len.push_back(2 * G + T + (NPIX + 1) * 50);
    wait (strobes == 4 * NPIX);
    repeat (5) @(negedge clk);
    chk(q_px.size() == 0, "R1 all pixels seen", q_px.size(), 0);
    chk(q_len.size() == 0, "R3 all lines seen", q_len.size(), 0);
    chk(tg_rises == 4, "R10 line count", tg_rises, 4);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (60000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=%0d", strobes, 4 * NPIX);
    finish_run();
  end
endmodule